// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Snapshot

This block is a calendar clock that keeps seconds, minutes, hours, day of month, month, two-digit year and weekday as packed BCD bytes. A fast input tick, nominally 32.768 kHz, is divided internally into one advance per second. Rollover runs through the full Gregorian calendar for the years 2000 to 2099, with leap Februaries.

Software reaches the clock through a byte-wide register port with a combinational read and a single-cycle write strobe. A stop bit freezes counting and holds the divider so that a multi-byte time update cannot tear. A snapshot request copies the whole live time into shadow bytes in a single cycle. A read-select bit then decides whether the time addresses return the live count or that frozen copy. This lets a slow serial host read seven bytes that all belong to the same second.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the time reads 00:00:00 on day 0x01, month 0x01, year 0x00, weekday 0x06. The control byte (address 8) reads 0x00 and the status byte (address 9) reads 0x02.
- R2: The time bytes sit at addresses 0 to 6 in this order: seconds, minutes, hours, day, month, year, weekday. A write keeps only the valid bits: 7 for seconds and minutes, 6 for hours and day, 5 for month, 8 for year and 3 for weekday.
- R3: While running, the seconds advance once per TICKS_PER_SEC cycles with `tick` high. Seconds and minutes wrap after 0x59, and hours wrap after 0x23, each carrying into the next field.
- R4: A day wraps to 0x01 after the last day of its month. April, June, September and November (0x11) have 30 days. The others have 31, except February. Day 0x30 of month 0x11 is followed by 0x01 of month 0x12. After December 31 the month becomes 0x01 and the year advances, wrapping from 0x99 to 0x00.
- R5: February has 29 days when the year value is divisible by 4 and 28 days otherwise.
- R6: The weekday advances at each midnight through 0 to 6 and wraps from 6 to 0. It never holds 7: a write of 7 stores 0.
- R7: While control bit 0 (stop) is 1, no time byte changes except by a write. The divider is held at zero, so after stop clears the first advance comes a full TICKS_PER_SEC ticks later.
- R8: A control write that takes bit 6 from 0 to 1 copies all seven live bytes into the shadow and sets status bit 2. A control write with bit 6 already 1 leaves the shadow unchanged.
- R9: With control bit 7 set, addresses 0 to 6 read the shadow. With it clear, they read the live count. The control byte reads back bits 7, 6 and 0, and its other bits read 0.
- R10: Status bit 0 mirrors the stop bit and cannot be cleared by a write. Bits 1 (set by reset) and 2 (snapshot taken) clear when a 1 is written to them.
- R11: Address 7 and addresses 10 to 15 read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Divider enable, one pulse per 32.768 kHz period |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |

## Verification
On every cycle the assertions check five things:
- The weekday never holds 7.
- A stopped clock changes only through writes, and the second enable stays quiet while stopped.
- The shadow matches the previous live time after a rising snapshot request and is otherwise stable.
- Seconds wrap from 0x59 to zero.
- November 30 at 23:59:59 rolls into December 1.

Month lengths for every month, leap and non-leap Februaries, the year wrap, the divider restart after stop, register masking, the read selection and the status write-one-to-clear can only be shown by the bench. It writes dates near rollovers, runs a known number of seconds and compares against a calendar model.

// File: rtl/bcd_rtc.sv
module bcd_rtc #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [DW-1:0] DLAST = DW'(TICKS_PER_SEC - 1);
  localparam logic [AW-1:0] A_CTRL = AW'(8);
  localparam logic [AW-1:0] A_STAT = AW'(9);
  localparam logic [AW-1:0] A_TEND = AW'(7);

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] fmask(input int i);
    case (i)
      0, 1:    return 8'h7F;
      2, 3:    return 8'h3F;
      4:       return 8'h1F;
      5:       return 8'hFF;
      default: return 8'h07;
    endcase
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
    logic [4:0] s;
    s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
    case (mon)
      8'h02:                      return (s[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  logic [6:0][7:0] tm, shd;
  logic [DW-1:0]   div;
  logic            stop, snap_req, rsel, pwr_flag, snap_flag;
  logic            sec_en, c_sec, c_min, c_hr, c_mon, c_yr;
  logic            wr_time, snap_go;

  assign wr_time = wr_en && (addr < A_TEND);
  assign snap_go = wr_en && (addr == A_CTRL) && wdata[6] && !snap_req;
  assign sec_en  = tick && !stop && (div == DLAST);
  assign c_sec   = sec_en && (tm[0] >= 8'h59);
  assign c_min   = c_sec  && (tm[1] >= 8'h59);
  assign c_hr    = c_min  && (tm[2] >= 8'h23);
  assign c_mon   = c_hr   && (tm[3] >= last_day(tm[4], tm[5]));
  assign c_yr    = c_mon  && (tm[4] >= 8'h12);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           div <= '0;
    else if (stop)        div <= '0;
    else if (tick)        div <= (div == DLAST) ? '0 : div + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tm <= {8'h06, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
    end else begin
      if (sec_en) tm[0] <= c_sec ? 8'h00 : bcd_inc(tm[0]);
      if (c_sec)  tm[1] <= c_min ? 8'h00 : bcd_inc(tm[1]);
      if (c_min)  tm[2] <= c_hr  ? 8'h00 : bcd_inc(tm[2]);
      if (c_hr) begin
        tm[3] <= c_mon ? 8'h01 : bcd_inc(tm[3]);
        tm[6] <= (tm[6] >= 8'h06) ? 8'h00 : tm[6] + 8'h01;
      end
      if (c_mon)  tm[4] <= c_yr ? 8'h01 : bcd_inc(tm[4]);
      if (c_yr)   tm[5] <= (tm[5] >= 8'h99) ? 8'h00 : bcd_inc(tm[5]);
      if (wr_time) begin
        for (int i = 0; i < 7; i++) begin
          if (addr == AW'(i)) begin
            if (i == 6 && wdata[2:0] == 3'd7) tm[i] <= 8'h00;
            else                              tm[i] <= wdata & fmask(i);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd <= {8'h06, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
    end else if (snap_go) begin
      shd <= tm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop      <= 1'b0;
      snap_req  <= 1'b0;
      rsel      <= 1'b0;
      pwr_flag  <= 1'b1;
      snap_flag <= 1'b0;
    end else begin
      if (wr_en && addr == A_CTRL) begin
        stop     <= wdata[0];
        snap_req <= wdata[6];
        rsel     <= wdata[7];
      end
      if (wr_en && addr == A_STAT) begin
        if (wdata[1]) pwr_flag  <= 1'b0;
        if (wdata[2]) snap_flag <= 1'b0;
      end
      if (snap_go) snap_flag <= 1'b1;
    end
  end

  always_comb begin
    if (addr < A_TEND)        rdata = rsel ? shd[addr[2:0]] : tm[addr[2:0]];
    else if (addr == A_CTRL)  rdata = {rsel, snap_req, 5'b0, stop};
    else if (addr == A_STAT)  rdata = {5'b0, snap_flag, pwr_flag, stop};
    else                      rdata = 8'h00;
  end
endmodule

module bcd_rtc_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sec_en,
  input logic          stop,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic          snap_bit,
  input logic          snap_req,
  input logic [55:0]   tm,
  input logic [55:0]   shd
);
  logic wr_t, snap_edge;
  assign wr_t      = wr_en && (addr < AW'(7));
  assign snap_edge = wr_en && (addr == AW'(8)) && snap_bit && !snap_req;

  p_wday_never7_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tm[50:48] != 3'd7);

  p_stop_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !wr_t) |=> $stable(tm));

  p_no_second_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> !sec_en);

  p_snap_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snap_edge |=> (shd == $past(tm)));

  p_snap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_edge |=> $stable(shd));

  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_en && tm[7:0] == 8'h59 && !(wr_en && addr == AW'(0))) |=> tm[7:0] == 8'h00);

  p_nov_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_en && !wr_t && tm[23:0] == 24'h235959 && tm[39:24] == 16'h1130)
      |=> tm[39:24] == 16'h1201);
endmodule

bind bcd_rtc bcd_rtc_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_en(sec_en), .stop(stop), .wr_en(wr_en),
  .addr(addr), .snap_bit(wdata[6]), .snap_req(snap_req), .tm(tm), .shd(shd)
);

// File: tb/bcd_rtc_tb.sv
`timescale 1ns/1ps
module bcd_rtc_tb;
  localparam int TPS = 4;
  localparam int AW  = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  int checks = 0, fails = 0;
  int ms, mm, mh, md, mo, my, mw;

  bcd_rtc #(.TICKS_PER_SEC(TPS), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  always #2.5 clk = ~clk;

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    addr = AW'(a);
    #1 v = rdata;
  endtask

  task automatic expect_reg(input string req, input int a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic adv1();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0; mw = (mw + 1) % 7; md++;
          if (md > dim(mo, my)) begin
            md = 1; mo++;
            if (mo > 12) begin mo = 1; my = (my + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic set_time(input int s, input int mi, input int h, input int d,
                          input int mon, input int y, input int w);
    ms = s; mm = mi; mh = h; md = d; mo = mon; my = y; mw = w;
    wr(8, 8'h01);
    wr(0, bcd(s)); wr(1, bcd(mi)); wr(2, bcd(h)); wr(3, bcd(d));
    wr(4, bcd(mon)); wr(5, bcd(y)); wr(6, bcd(w));
  endtask

  task automatic run_secs(input int k);
    wr(8, 8'h00);
    repeat (TPS * k - 1) @(posedge clk);
    wr(8, 8'h01);
    for (int i = 0; i < k; i++) adv1();
  endtask

  task automatic check_model(input string req);
    expect_reg(req, 0, bcd(ms)); expect_reg(req, 1, bcd(mm));
    expect_reg(req, 2, bcd(mh)); expect_reg(req, 3, bcd(md));
    expect_reg(req, 4, bcd(mo)); expect_reg(req, 5, bcd(my));
    expect_reg(req, 6, bcd(mw));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1357);
    tick = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset values
    ms = 0; mm = 0; mh = 0; md = 1; mo = 1; my = 0; mw = 6;
    check_model("R1");
    expect_reg("R1", 8, 8'h00);
    expect_reg("R1", 9, 8'h02);
    tick = 1'b1;

    // R10: status bits
    wr(9, 8'h02);
    expect_reg("R10", 9, 8'h00);
    wr(8, 8'h01);
    expect_reg("R10", 9, 8'h01);
    wr(9, 8'h01);
    expect_reg("R10", 9, 8'h01);

    // R2: field masks, R6: weekday 7 stored as 0
    wr(0, 8'hFF); expect_reg("R2", 0, 8'h7F);
    wr(2, 8'hFF); expect_reg("R2", 2, 8'h3F);
    wr(4, 8'hFF); expect_reg("R2", 4, 8'h1F);
    wr(5, 8'hFF); expect_reg("R2", 5, 8'hFF);
    wr(6, 8'h07); expect_reg("R6", 6, 8'h00);

    // R11: unmapped addresses
    set_time(10, 20, 5, 15, 6, 21, 2);
    wr(7, 8'h55); wr(12, 8'hAA);
    expect_reg("R11", 7, 8'h00);
    expect_reg("R11", 12, 8'h00);
    check_model("R11");

    // R7: stop holds count; divider restarts from zero
    wr(8, 8'h00);
    @(posedge clk);
    wr(8, 8'h01);
    check_model("R7");
    repeat (20) @(posedge clk);
    check_model("R7");
    run_secs(1);
    check_model("R7");

    // R3/R4: November end, year wrap
    set_time(59, 59, 23, 30, 11, 24, 3); run_secs(1); check_model("R4");
    set_time(59, 59, 23, 31, 12, 99, 6); run_secs(1); check_model("R4");
    set_time(58, 59, 23, 30, 4, 10, 1);  run_secs(3); check_model("R4");
    // R5: leap and non-leap February
    set_time(59, 59, 23, 28, 2, 24, 0);  run_secs(1); check_model("R5");
    set_time(59, 59, 23, 29, 2, 24, 0);  run_secs(1); check_model("R5");
    set_time(59, 59, 23, 28, 2, 23, 0);  run_secs(1); check_model("R5");
    // R6: weekday wrap
    set_time(59, 59, 23, 5, 7, 30, 6);   run_secs(1); check_model("R6");

    // R8/R9: snapshot and read select
    set_time(12, 34, 11, 9, 3, 45, 4);
    wr(8, 8'h41);
    expect_reg("R8", 9, 8'h05);
    wr(0, bcd(33));
    wr(8, 8'hC1);
    expect_reg("R9", 8, 8'hC1);
    expect_reg("R8", 0, bcd(12));
    expect_reg("R9", 1, bcd(34));
    wr(8, 8'h01);
    expect_reg("R9", 0, bcd(33));
    wr(9, 8'h04);
    expect_reg("R10", 9, 8'h01);
    wr(8, 8'hC1);
    expect_reg("R8", 0, bcd(33));
    expect_reg("R8", 9, 8'h05);
    wr(8, 8'h01);

    // R3..R6: random dates biased toward rollovers
    for (int it = 0; it < 80; it++) begin
      int y, mon, d, h, mi, s, w, k;
      y   = $urandom_range(0, 99);
      mon = $urandom_range(1, 12);
      d   = ($urandom_range(0, 1) == 1) ? dim(mon, y) : $urandom_range(1, dim(mon, y));
      h   = ($urandom_range(0, 1) == 1) ? 23 : $urandom_range(0, 23);
      mi  = ($urandom_range(0, 2) != 0) ? 59 : $urandom_range(0, 59);
      s   = $urandom_range(55, 59);
      w   = $urandom_range(0, 6);
      k   = $urandom_range(1, 6);
      set_time(s, mi, h, d, mon, y, w);
      run_secs(k);
      check_model("R3");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule